// File: doc/BRIEF.md
# Predicated Floating-Point Min/Max Reduction

This block folds a packed vector of IEEE floating-point elements into one scalar under a per-byte predicate. It supports four operations: minimum, maximum, and the number-preferring forms of each. Elements can be half, single or double precision. The caller presents the vector, the predicate, the element-size and operation codes and the active vector length, then pulses a start strobe. Some cycles later the block raises a one-cycle done strobe. The result is held, zero-extended to 64 bits, until the next accepted start.

Before any combining, the block substitutes an operation-specific identity value into two kinds of lane: those whose predicate bit is clear, and those lying past the active length. The element count is then padded to a power of two. The lanes are then combined in a fixed binary tree, one level per clock. Each level merges neighbouring pairs with the lower-indexed operand first, so NaN selection follows a fixed order and repeated runs give identical results.

Top module: `fpred_minmax_reduce`

## Requirements
- R1: Each element's predicate is the predicate bit at the element's lowest byte offset (bit 2i for half, 4i for single, 8i for double); the other predicate bits have no effect.
- R2: An element whose predicate bit is clear takes the identity value of the operation. For the number-preferring forms this is the default quiet NaN (0x7E00, 0x7FC00000, 0x7FF8000000000000). Plain minimum uses +infinity and plain maximum uses -infinity, in the selected precision.
- R3: Elements at byte offsets at or above the active length are filled with the identity value. Their data and predicate bits do not affect the result. The element count is the active length rounded up to a power of two bytes, divided by the element size.
- R4: Elements are combined pairwise as (lower, upper), neighbour by neighbour and level by level, so that element 0's subtree is always the first operand.
- R5: In plain minimum and maximum, if either operand is a NaN the result is the first NaN operand in (lower, upper) order, quietened by setting its top fraction bit.
- R6: In the number-preferring forms, when neither operand is a signalling NaN and exactly one is a NaN, the other operand is returned. In every other NaN case the R5 rule applies.
- R7: Minimum orders -0 below +0 and maximum orders +0 above -0.
- R8: Operation codes are 3'b100 number-max, 3'b101 number-min, 3'b110 max and 3'b111 min. Element-size codes are 1 half, 2 single and 3 double. The active length must be a nonzero multiple of 16 bytes no larger than the vector. A start with any other code or length is ignored: no done is raised and the result is unchanged.
- R9: Done is high for one cycle exactly L cycles after the cycle in which start is accepted. L is log2 of the padded length in bytes minus the element-size code.
- R10: The result is zero-extended above the element width. It stays unchanged from done until the next accepted start. A start while a reduction is in progress is ignored.
- R11: After reset, done is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle and the command is valid |
| vec_i | input | VBYTES*8 | Packed element data, element i at bit offset i times element width |
| pred_i | input | VBYTES | Predicate, one bit per data byte |
| esize_i | input | 2 | Element-size code |
| op_i | input | 3 | Operation code |
| vlen_i | input | $clog2(VBYTES)+1 | Active vector length in bytes |
| result_o | output | 64 | Reduced scalar, zero-extended |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with VBYTES = 64. At that size all four legal active lengths (16, 32, 48, 64) can be reached, and so can the padded case where 48 bytes round up to 64. The tree depth then ranges from one level (double precision, 16 bytes) to five levels (half precision, 64 bytes). This covers both the case where the first level's result is already final and the longest countdown. A queue-based behavioural model predicts done and the held result on every clock.

// File: rtl/fpred_pkg.sv
package fpred_pkg;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_HALF   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fpred_fmt_e;

    localparam logic [2:0] OPC_NUM_MAX = 3'b100;
    localparam logic [2:0] OPC_NUM_MIN = 3'b101;
    localparam logic [2:0] OPC_MAX     = 3'b110;
    localparam logic [2:0] OPC_MIN     = 3'b111;

    typedef struct packed {
        logic        sign;
        logic        nan;
        logic        quiet;
        logic [62:0] mag;
        logic [63:0] qbit;
    } fpred_fields_t;

    function automatic fpred_fields_t fpred_unpack(logic [63:0] x, logic [1:0] fmt);
        fpred_fields_t f;
        f = '0;
        case (fmt)
            FMT_HALF: begin
                f.sign  = x[15];
                f.nan   = (&x[14:10]) && (|x[9:0]);
                f.quiet = x[9];
                f.mag   = {48'd0, x[14:0]};
                f.qbit  = 64'h0000_0000_0000_0200;
            end
            FMT_SINGLE: begin
                f.sign  = x[31];
                f.nan   = (&x[30:23]) && (|x[22:0]);
                f.quiet = x[22];
                f.mag   = {32'd0, x[30:0]};
                f.qbit  = 64'h0000_0000_0040_0000;
            end
            default: begin
                f.sign  = x[63];
                f.nan   = (&x[62:52]) && (|x[51:0]);
                f.quiet = x[51];
                f.mag   = x[62:0];
                f.qbit  = 64'h0008_0000_0000_0000;
            end
        endcase
        return f;
    endfunction

    function automatic logic [63:0] fpred_identity(logic [1:0] fmt, logic is_max, logic is_num);
        logic [63:0] v;
        case (fmt)
            FMT_HALF:   v = is_num ? 64'h7E00 : (is_max ? 64'hFC00 : 64'h7C00);
            FMT_SINGLE: v = is_num ? 64'h7FC0_0000 : (is_max ? 64'hFF80_0000 : 64'h7F80_0000);
            default:    v = is_num ? 64'h7FF8_0000_0000_0000 :
                            (is_max ? 64'hFFF0_0000_0000_0000 : 64'h7FF0_0000_0000_0000);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fpred_cell.sv
module fpred_cell
    import fpred_pkg::*;
(
    input  logic [63:0] lo_i,
    input  logic [63:0] hi_i,
    input  logic [1:0]  fmt_i,
    input  logic        is_max_i,
    input  logic        is_num_i,
    output logic [63:0] y_o
);

    fpred_fields_t lo_f;
    fpred_fields_t hi_f;
    logic          lo_below;
    logic          pick_hi;
    logic          snan_seen;

    always_comb begin
        lo_f = fpred_unpack(lo_i, fmt_i);
        hi_f = fpred_unpack(hi_i, fmt_i);

        // signed-magnitude ordering; -0 sits below +0
        if (lo_f.sign != hi_f.sign) begin
            lo_below = lo_f.sign;
        end else if (lo_f.sign) begin
            lo_below = lo_f.mag > hi_f.mag;
        end else begin
            lo_below = lo_f.mag < hi_f.mag;
        end
        pick_hi   = is_max_i ? lo_below : !lo_below;
        snan_seen = (lo_f.nan && !lo_f.quiet) || (hi_f.nan && !hi_f.quiet);

        if (is_num_i && !snan_seen && (lo_f.nan != hi_f.nan)) begin
            y_o = lo_f.nan ? hi_i : lo_i;
        end else if (lo_f.nan) begin
            y_o = lo_i | lo_f.qbit;
        end else if (hi_f.nan) begin
            y_o = hi_i | hi_f.qbit;
        end else begin
            y_o = pick_hi ? hi_i : lo_i;
        end
    end

endmodule

// File: rtl/fpred_load.sv
module fpred_load
    import fpred_pkg::*;
#(
    parameter int VBYTES = 64
) (
    input  logic [VBYTES*8-1:0]          vec_i,
    input  logic [VBYTES-1:0]            pred_i,
    input  logic [$clog2(VBYTES):0]      vlen_i,
    input  logic [1:0]                   fmt_i,
    input  logic                         is_max_i,
    input  logic                         is_num_i,
    output logic [VBYTES/2-1:0][63:0]    lanes_o
);

    localparam int LANES = VBYTES / 2;
    localparam int VLW   = $clog2(VBYTES) + 1;

    logic [63:0]        ident;
    logic [LANES-1:0]   pred_unused_bits;

    assign ident = fpred_identity(fmt_i, is_max_i, is_num_i);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [63:0] h_v;
        logic [63:0] s_v;
        logic [63:0] d_v;

        assign pred_unused_bits[i] = pred_i[2*i+1];

        assign h_v = ((VLW'(2*i) < vlen_i) && pred_i[2*i]) ? {48'd0, vec_i[16*i +: 16]} : ident;

        if (i < LANES / 2) begin : g_s
            assign s_v = ((VLW'(4*i) < vlen_i) && pred_i[4*i]) ? {32'd0, vec_i[32*i +: 32]} : ident;
        end else begin : g_s_pad
            assign s_v = ident;
        end

        if (i < LANES / 4) begin : g_d
            assign d_v = ((VLW'(8*i) < vlen_i) && pred_i[8*i]) ? vec_i[64*i +: 64] : ident;
        end else begin : g_d_pad
            assign d_v = ident;
        end

        assign lanes_o[i] = (fmt_i == FMT_SINGLE) ? s_v :
                            (fmt_i == FMT_DOUBLE) ? d_v : h_v;
    end

endmodule

// File: rtl/fpred_level.sv
module fpred_level
    import fpred_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0][63:0] in_i,
    input  logic [1:0]             fmt_i,
    input  logic                   is_max_i,
    input  logic                   is_num_i,
    output logic [LANES-1:0][63:0] out_o
);

    localparam int PAIRS = LANES / 2;

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        fpred_cell u_cell (
            .lo_i     (in_i[2*i]),
            .hi_i     (in_i[2*i+1]),
            .fmt_i    (fmt_i),
            .is_max_i (is_max_i),
            .is_num_i (is_num_i),
            .y_o      (out_o[i])
        );
    end

    for (genvar i = PAIRS; i < LANES; i++) begin : g_keep
        assign out_o[i] = in_i[i];
    end

endmodule

// File: rtl/fpred_minmax_reduce.sv
module fpred_minmax_reduce
    import fpred_pkg::*;
#(
    parameter int VBYTES = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [VBYTES*8-1:0]        vec_i,
    input  logic [VBYTES-1:0]          pred_i,
    input  logic [1:0]                 esize_i,
    input  logic [2:0]                 op_i,
    input  logic [$clog2(VBYTES):0]    vlen_i,
    output logic [63:0]                result_o,
    output logic                       done_o
);

    localparam int LANES = VBYTES / 2;
    localparam int LGMAX = $clog2(VBYTES);
    localparam int CW    = $clog2(LGMAX + 1);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [CW-1:0]           cnt;
        logic [1:0]              fmt;
        logic                    is_max;
        logic                    is_num;
        logic [LANES-1:0][63:0]  lanes;
    } fpred_state_t;

    fpred_state_t st_d, st_q;

    logic                   cmd_ok;
    logic                   accept;
    logic [CW-1:0]          levels;
    int                     lg_len;
    logic [LANES-1:0][63:0] loaded;
    logic [LANES-1:0][63:0] lvl_src;
    logic [LANES-1:0][63:0] lvl_out;
    logic [1:0]             c_fmt;
    logic                   c_max;
    logic                   c_num;

    // command decode and tree depth
    always_comb begin
        cmd_ok = op_i[2] && (esize_i != 2'd0) && (vlen_i != '0) &&
                 (vlen_i[3:0] == 4'd0) && (int'(vlen_i) <= VBYTES);
        lg_len = 0;
        for (int k = LGMAX; k >= 0; k--) begin
            if ((1 << k) >= int'(vlen_i)) lg_len = k;
        end
        levels = CW'(lg_len - int'(esize_i));
        accept = start_i && !st_q.busy && cmd_ok;
    end

    fpred_load #(.VBYTES(VBYTES)) u_load (
        .vec_i    (vec_i),
        .pred_i   (pred_i),
        .vlen_i   (vlen_i),
        .fmt_i    (esize_i),
        .is_max_i (~op_i[0]),
        .is_num_i (~op_i[1]),
        .lanes_o  (loaded)
    );

    // operand source: fresh lanes on accept, stored lanes otherwise
    always_comb begin
        lvl_src = st_q.lanes;
        c_fmt   = st_q.fmt;
        c_max   = st_q.is_max;
        c_num   = st_q.is_num;
        if (accept) begin
            lvl_src = loaded;
            c_fmt   = esize_i;
            c_max   = ~op_i[0];
            c_num   = ~op_i[1];
        end
    end

    fpred_level #(.LANES(LANES)) u_level (
        .in_i     (lvl_src),
        .fmt_i    (c_fmt),
        .is_max_i (c_max),
        .is_num_i (c_num),
        .out_o    (lvl_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.fmt    = esize_i;
            st_d.is_max = ~op_i[0];
            st_d.is_num = ~op_i[1];
            st_d.lanes  = lvl_out;
            st_d.cnt    = levels - CW'(1);
            st_d.busy   = (levels != CW'(1));
            st_d.done   = (levels == CW'(1));
        end else if (st_q.busy) begin
            st_d.lanes = lvl_out;
            st_d.cnt   = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.lanes[0];
    assign done_o   = st_q.done;

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (st_q.cnt > CW'(1))) |=> (st_q.busy && (st_q.cnt == $past(st_q.cnt) - CW'(1))));

    assert_bad_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.busy && !cmd_ok) |=> (!done_o && $stable(result_o)));

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !(start_i && cmd_ok)) |=> $stable(result_o));

    assert_zero_extend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((st_q.fmt == FMT_HALF)   ? (result_o[63:16] == '0) :
                    (st_q.fmt == FMT_SINGLE) ? (result_o[63:32] == '0) : 1'b1));

endmodule

// File: tb/fpred_minmax_reduce_bench.sv
`timescale 1ns/1ps
module fpred_minmax_reduce_bench;

    localparam int VB  = 64;
    localparam int VLW = $clog2(VB) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VB*8-1:0] vec_r = '0;
    logic [VB-1:0]   pred_r = '0;
    logic [1:0]      es_r = 2'd1;
    logic [2:0]      op_r = 3'b110;
    logic [VLW-1:0]  vlen_r = VLW'(16);
    logic [63:0]     result_o;
    logic            done_o;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    string cur_req = "R11";
    logic [63:0] last_exp = '0;

    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_cnt = 0;
    logic [63:0] m_res = '0;
    logic [63:0] m_pend = '0;

    always #10 clk = ~clk;

    fpred_minmax_reduce #(.VBYTES(VB)) u_fpred_minmax_reduce (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .vec_i    (vec_r),
        .pred_i   (pred_r),
        .esize_i  (es_r),
        .op_i     (op_r),
        .vlen_i   (vlen_r),
        .result_o (result_o),
        .done_o   (done_o)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int fw_of(int es);
        return (es == 1) ? 10 : (es == 2) ? 23 : 52;
    endfunction

    function automatic int ew_of(int es);
        return (es == 1) ? 5 : (es == 2) ? 8 : 11;
    endfunction

    function automatic logic [63:0] b_ident(int es, logic [2:0] op);
        if (!op[1]) return (es == 1) ? 64'h7E00 : (es == 2) ? 64'h7FC00000 : 64'h7FF8000000000000;
        if (op[0])  return (es == 1) ? 64'h7C00 : (es == 2) ? 64'h7F800000 : 64'h7FF0000000000000;
        return (es == 1) ? 64'hFC00 : (es == 2) ? 64'hFF800000 : 64'hFFF0000000000000;
    endfunction

    function automatic bit b_isnan(logic [63:0] x, int es);
        logic [63:0] e = (x >> fw_of(es)) & ((64'd1 << ew_of(es)) - 1);
        logic [63:0] f = x & ((64'd1 << fw_of(es)) - 1);
        return (e == ((64'd1 << ew_of(es)) - 1)) && (f != 0);
    endfunction

    function automatic logic signed [65:0] b_key(logic [63:0] x, int es);
        int tw = 1 + ew_of(es) + fw_of(es);
        logic [63:0] mag = x & ((64'd1 << (tw - 1)) - 1);
        logic signed [65:0] m2 = $signed({2'b00, mag}) * 2;
        return x[tw-1] ? -m2 : m2 + 1;
    endfunction

    function automatic logic [63:0] b_op(logic [63:0] a, logic [63:0] b, int es, logic [2:0] op);
        logic [63:0] qb = 64'd1 << (fw_of(es) - 1);
        bit an = b_isnan(a, es);
        bit bn = b_isnan(b, es);
        bit sig = (an && ((a & qb) == 0)) || (bn && ((b & qb) == 0));
        if (!op[1] && !sig && (an != bn)) return an ? b : a;
        if (an) return a | qb;
        if (bn) return b | qb;
        if (op[0]) return (b_key(b, es) < b_key(a, es)) ? b : a;
        return (b_key(b, es) > b_key(a, es)) ? b : a;
    endfunction

    function automatic int b_p2(int vl);
        int p = 16;
        while (p < vl) p = p * 2;
        return p;
    endfunction

    function automatic int b_levels(int vl, int es);
        int p = b_p2(vl);
        int lg = 0;
        while ((1 << lg) < p) lg++;
        return lg - es;
    endfunction

    function automatic bit b_valid(logic [2:0] op, int es, int vl);
        return op[2] && (es >= 1) && (es <= 3) && (vl > 0) && (vl % 16 == 0) && (vl <= VB);
    endfunction

    function automatic logic [63:0] b_ref(logic [VB*8-1:0] v, logic [VB-1:0] p, int es, logic [2:0] op, int vl);
        int bsz = 1 << es;
        int n = b_p2(vl) / bsz;
        logic [63:0] msk = (bsz == 8) ? '1 : ((64'd1 << (bsz * 8)) - 1);
        logic [63:0] q[$];
        for (int i = 0; i < n; i++) begin
            int off = i * bsz;
            logic [VB*8-1:0] t = v >> (off * 8);
            if (off < vl && p[off]) q.push_back(t[63:0] & msk);
            else q.push_back(b_ident(es, op));
        end
        while (q.size() > 1) begin
            logic [63:0] nq[$];
            for (int j = 0; j < q.size() / 2; j++) nq.push_back(b_op(q[2*j], q[2*j+1], es, op));
            q = nq;
        end
        return q[0];
    endfunction

    function automatic logic [VB*8-1:0] put(logic [VB*8-1:0] v, int es, int i, logic [63:0] x);
        int w = 8 << es;
        for (int b = 0; b < w; b++) v[i*w + b] = x[b];
        return v;
    endfunction

    function automatic logic [63:0] h_pat(int i);
        return {48'd0, i[0], 5'(i % 30), 10'((i * 37) % 1024)};
    endfunction

    function automatic logic [63:0] s_pat(int i);
        return {32'd0, i[1], 8'(100 + i * 3), 23'(i * 12345)};
    endfunction

    function automatic logic [63:0] d_pat(int i);
        return {i[2], 11'(1000 + i * 7), 52'(i * 98765)};
    endfunction

    // behavioural reference: predicted done and held result
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
            end else if (start && b_valid(op_r, int'(es_r), int'(vlen_r))) begin
                m_pend = b_ref(vec_r, pred_r, int'(es_r), op_r, int'(vlen_r));
                m_cnt = b_levels(int'(vlen_r), int'(es_r)) - 1;
                if (m_cnt == 0) begin m_done = 1; m_res = m_pend; end
                else m_busy = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done_o === m_done, "R9", {63'd0, done_o}, {63'd0, m_done});
            if (!m_busy) chk(result_o === m_res, cur_req, result_o, m_res);
        end
    end

    task automatic go(logic [2:0] op, int es, int vl, logic [VB*8-1:0] v, logic [VB-1:0] p, string req);
        bit ok = b_valid(op, es, vl);
        logic [63:0] exp = ok ? b_ref(v, p, es, op, vl) : last_exp;
        int nd;
        @(negedge clk);
        cur_req = req; op_r = op; es_r = 2'(es); vlen_r = VLW'(vl); vec_r = v; pred_r = p; start = 1;
        @(negedge clk);
        start = 0;
        nd = int'(done_o);
        repeat (7) begin @(negedge clk); nd += int'(done_o); end
        chk(nd == (ok ? 1 : 0), req, 64'(nd), ok ? 64'd1 : 64'd0);
        chk(result_o === exp, req, result_o, exp);
        last_exp = exp;
    endtask

    initial begin
        logic [VB*8-1:0] v;
        logic [VB*8-1:0] v2;
        logic [63:0] ex;

        repeat (3) @(negedge clk);
        chk(done_o === 1'b0, "R11", {63'd0, done_o}, 64'd0);
        chk(result_o === 64'd0, "R11", result_o, 64'd0);
        rst_n = 1;

        // R4 / R9: half precision, five levels, all lanes live
        v = '0;
        for (int i = 0; i < 32; i++) v = put(v, 1, i, h_pat(i));
        go(3'b110, 1, 64, v, '1, "R4");
        go(3'b111, 1, 64, v, '1, "R4");
        go(3'b100, 1, 64, v, '1, "R9");
        go(3'b101, 1, 32, v, '1, "R9");

        // R1: only the lowest byte's predicate bit counts
        v = '0;
        for (int i = 0; i < 16; i++) v = put(v, 2, i, s_pat(i));
        go(3'b111, 2, 64, v, 64'h2222_2222_2222_2222, "R1");
        go(3'b111, 2, 64, v, 64'h1111_1111_1111_1111, "R1");
        go(3'b110, 2, 64, v, 64'hEEEE_0000_0101_F0F1, "R1");

        // R2: every lane inactive yields the identity
        for (int es = 1; es <= 3; es++)
            for (int op = 4; op <= 7; op++)
                go(3'(op), es, 32, v, '0, "R2");

        // R3: lanes past the active length are ignored
        v = '0;
        for (int i = 0; i < 32; i++) v = put(v, 1, i, (i < 24) ? 64'h3C00 + 64'(i) : 64'h7BFF);
        go(3'b110, 1, 48, v, '1, "R3");
        v = '0;
        for (int i = 0; i < 8; i++) v = put(v, 3, i, d_pat(i));
        go(3'b111, 3, 16, v, '1, "R3");
        go(3'b110, 3, 64, v, '1, "R9");

        // R5: plain forms quieten and keep the first NaN
        v = '0;
        for (int i = 0; i < 16; i++) v = put(v, 2, i, s_pat(i));
        v2 = put(v, 2, 3, 64'h7F800001);
        go(3'b110, 2, 64, v2, '1, "R5");
        v2 = put(put(v, 2, 0, 64'h7FC00005), 2, 1, 64'h7FC00009);
        go(3'b110, 2, 64, v2, '1, "R5");
        v = '0;
        for (int i = 0; i < 8; i++) v = put(v, 3, i, d_pat(i));
        go(3'b111, 3, 64, put(v, 3, 5, 64'hFFF0000000000001), '1, "R5");

        // R6: number-preferring forms skip a single quiet NaN
        go(3'b101, 3, 64, put(v, 3, 2, 64'h7FF8000000000003), '1, "R6");
        v2 = '0;
        for (int i = 0; i < 16; i++) v2 = put(v2, 2, i, s_pat(i));
        go(3'b101, 2, 64, put(v2, 2, 4, 64'h7F800002), '1, "R6");
        v2 = '0;
        for (int i = 0; i < 32; i++) v2 = put(v2, 1, i, (i == 7) ? 64'h4500 : 64'h7E01);
        go(3'b100, 1, 64, v2, '1, "R6");

        // R7: signed zero ordering
        v = put(put('0, 1, 0, 64'h0000), 1, 1, 64'h8000);
        go(3'b111, 1, 16, v, 64'h5, "R7");
        go(3'b110, 1, 16, v, 64'h5, "R7");
        v = put(put('0, 1, 0, 64'h8000), 1, 1, 64'h0000);
        go(3'b110, 1, 16, v, 64'h5, "R7");
        go(3'b111, 1, 16, v, 64'h5, "R7");

        // R8: malformed commands are ignored
        go(3'b000, 1, 32, v, '1, "R8");
        go(3'b011, 2, 32, v, '1, "R8");
        go(3'b110, 0, 32, v, '1, "R8");
        go(3'b110, 1, 24, v, '1, "R8");
        go(3'b111, 1, 0, v, '1, "R8");
        go(3'b111, 1, 80, v, '1, "R8");

        // R10: a start while busy does not disturb the reduction
        v = '0;
        for (int i = 0; i < 32; i++) v = put(v, 1, i, h_pat(i));
        ex = b_ref(v, '1, 1, 3'b110, 64);
        @(negedge clk);
        cur_req = "R10"; op_r = 3'b110; es_r = 2'd1; vlen_r = VLW'(64); vec_r = v; pred_r = '1; start = 1;
        @(negedge clk);
        op_r = 3'b111; vec_r = ~v;
        @(negedge clk);
        start = 0;
        repeat (8) @(negedge clk);
        chk(result_o === ex, "R10", result_o, ex);
        last_exp = ex;
        repeat (4) @(negedge clk);
        chk(result_o === ex, "R10", result_o, ex);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule